// File: doc/BRIEF.md
# Linked Descriptor Schedule Walker

This block runs once per microframe and walks up to three singly linked chains of transfer descriptors kept in a local descriptor memory. Each chain has its own enable bit and head pointer. Chain 0 carries isochronous work, chain 1 carries interrupt work and chain 2 carries asynchronous work. The walker fetches one descriptor at a time through a synchronous read port and looks at two flags, "active" and "done". It then either hands the descriptor to a packet engine through a request/acknowledge handshake or passes over it. After that it follows the descriptor's link field.

A chain ends in one of three ways: the walker reads a null link, it reads a descriptor that carries the end-of-chain flag, or it has visited a fixed number of descriptors in that chain during the microframe. The third case guards against circular links and raises an error flag. An end-of-microframe input stops the walk early. A request that is still pending is allowed to finish, and the walker then waits for the next microframe-start strobe.

Top module: `sched_walker`

## Requirements
- R1: After reset, `busy`, `req_valid`, `mem_rd_en` and `loop_err` are all low.
- R2: Within one microframe, enabled chains are served strictly in index order: 0, then 1, then 2. A chain whose `list_en` bit is clear is passed over and none of its descriptors is read.
- R3: A descriptor read is a single-cycle `mem_rd_en` pulse, and `mem_rd_data` holds the word in the following cycle. The descriptor word has these fields:
  - bits [ADDR_W-1:0] hold the link;
  - bit ADDR_W is the end-of-chain flag;
  - bit ADDR_W+1 is active;
  - bit ADDR_W+2 is done.
- R4: A descriptor with active=1 and done=0 raises `req_valid` with its own address on `req_addr` and its chain index on `req_list`. These outputs hold steady until `req_ack` is seen, and only then does the walker move on.
- R5: Any other flag combination (inactive and done, active and done, inactive and not done) is passed over without a request, and the walker goes straight to the linked descriptor.
- R6: A link or head pointer of zero is null and ends the chain. Address 0 is never read, so a head pointer of zero makes the chain empty.
- R7: A descriptor with the end-of-chain flag set ends its chain even when its link is non-zero.
- R8: After `uframe_end`, no new read or request is started. A request that is already pending is held until `req_ack`, after which the walker goes idle. The next `uframe_start` begins a fresh walk from chain 0.
- R9: At most MAX_STEPS (default 32) descriptors are visited per chain per microframe. If a chain would continue past that, `loop_err` is set and the walk moves on to the next chain. `loop_err` is cleared by the next accepted `uframe_start`.
- R10: A `uframe_start` pulse that arrives while the walker is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uframe_start | input | 1 | Microframe start strobe |
| uframe_end | input | 1 | End-of-microframe strobe |
| list_en | input | 3 | Per-chain enable, bit i for chain i |
| list_head | input | 3*ADDR_W | Head pointers, chain i at bits [i*ADDR_W +: ADDR_W] |
| mem_rd_en | output | 1 | Descriptor memory read strobe |
| mem_rd_addr | output | ADDR_W | Descriptor memory read address |
| mem_rd_data | input | ADDR_W+3 | Descriptor word, valid one cycle after the read strobe |
| req_valid | output | 1 | Transaction request |
| req_addr | output | ADDR_W | Address of the descriptor to execute |
| req_list | output | 2 | Chain index of the request |
| req_ack | input | 1 | Request accepted |
| busy | output | 1 | Walk in progress |
| loop_err | output | 1 | Step limit was hit in this microframe |

## Verification
The hardest situation to reach from the ports is the step limit, because it needs a chain that never ends on its own. The bench builds a two-descriptor cycle in its memory model. The first descriptor of the cycle is active and the second is one to pass over. Walking this cycle gives exactly MAX_STEPS visits, half of which produce requests, and the bench then checks that the error flag is raised and that the next chain is still served. A second hard case is an end-of-microframe strobe that arrives while a request is pending. For this the bench stops acknowledging automatically, waits for a request, sends the strobe, and only then sends the acknowledge.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int LIST_N  = 3;
  localparam int LIST_IW = $clog2(LIST_N + 1);

  typedef enum logic [2:0] {
    W_IDLE,
    W_PICK,
    W_READ,
    W_EVAL,
    W_REQ
  } walk_state_t;
endpackage

// File: rtl/walk_list_pick.sv
module walk_list_pick #(
  parameter int ADDR_W  = 8,
  parameter int LIST_N  = 3,
  parameter int LIST_IW = 2
) (
  input  logic [LIST_N-1:0]        en,
  input  logic [LIST_IW-1:0]       from,
  input  logic [LIST_N*ADDR_W-1:0] heads,
  output logic                     found,
  output logic [LIST_IW-1:0]       idx,
  output logic [ADDR_W-1:0]        head
);
  // lowest enabled chain index at or above 'from' wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    head  = '0;
    for (int i = LIST_N - 1; i >= 0; i--) begin
      if (en[i] && (i >= int'(from))) begin
        found = 1'b1;
        idx   = LIST_IW'(i);
        head  = heads[i*ADDR_W +: ADDR_W];
      end
    end
  end
endmodule

// File: rtl/walk_step_guard.sv
module walk_step_guard #(
  parameter int MAX_STEPS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic at_limit
);
  localparam int CW = $clog2(MAX_STEPS + 1);

  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (rst || clear) count <= '0;
    else if (step)    count <= count + 1'b1;
  end

  assign at_limit = (count >= CW'(MAX_STEPS));

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(MAX_STEPS)); // R9
endmodule

// File: rtl/walk_desc_unpack.sv
module walk_desc_unpack #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W+2:0] desc,
  output logic [ADDR_W-1:0] link,
  output logic              tail,
  output logic              take
);
  logic active, done;

  assign link   = desc[ADDR_W-1:0];
  assign tail   = desc[ADDR_W];
  assign active = desc[ADDR_W+1];
  assign done   = desc[ADDR_W+2];
  assign take   = active && !done;
endmodule

// File: rtl/sched_walker.sv
module sched_walker
  import walk_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int MAX_STEPS = 32,
  localparam int DESC_W   = ADDR_W + 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     uframe_start,
  input  logic                     uframe_end,
  input  logic [LIST_N-1:0]        list_en,
  input  logic [LIST_N*ADDR_W-1:0] list_head,
  output logic                     mem_rd_en,
  output logic [ADDR_W-1:0]        mem_rd_addr,
  input  logic [DESC_W-1:0]        mem_rd_data,
  output logic                     req_valid,
  output logic [ADDR_W-1:0]        req_addr,
  output logic [LIST_IW-1:0]       req_list,
  input  logic                     req_ack,
  output logic                     busy,
  output logic                     loop_err
);
  walk_state_t        state;
  logic [LIST_IW-1:0] scan_from, cur_list;
  logic [ADDR_W-1:0]  ptr, link_q;
  logic               tail_q, eof_pend;

  logic               eof;
  logic               pick_found;
  logic [LIST_IW-1:0] pick_idx;
  logic [ADDR_W-1:0]  pick_head;
  logic [ADDR_W-1:0]  d_link;
  logic               d_tail, d_take;
  logic               at_limit;
  logic [ADDR_W-1:0]  adv_link;
  logic               adv_tail, adv_end, adv_err;

  walk_list_pick #(.ADDR_W(ADDR_W), .LIST_N(LIST_N), .LIST_IW(LIST_IW)) u_pick (
    .en(list_en), .from(scan_from), .heads(list_head),
    .found(pick_found), .idx(pick_idx), .head(pick_head)
  );

  walk_desc_unpack #(.ADDR_W(ADDR_W)) u_unpack (
    .desc(mem_rd_data), .link(d_link), .tail(d_tail), .take(d_take)
  );

  walk_step_guard #(.MAX_STEPS(MAX_STEPS)) u_guard (
    .clk(clk), .rst(rst),
    .clear(state == W_PICK), .step(state == W_READ),
    .at_limit(at_limit)
  );

  assign eof  = eof_pend || uframe_end;
  assign busy = (state != W_IDLE);

  // where to go after the current descriptor
  always_comb begin
    adv_link = (state == W_REQ) ? link_q : d_link;
    adv_tail = (state == W_REQ) ? tail_q : d_tail;
    adv_end  = adv_tail || (adv_link == '0);
    adv_err  = !adv_end && at_limit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= W_IDLE;
      scan_from   <= '0;
      cur_list    <= '0;
      ptr         <= '0;
      link_q      <= '0;
      tail_q      <= 1'b0;
      eof_pend    <= 1'b0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      req_valid   <= 1'b0;
      req_addr    <= '0;
      req_list    <= '0;
      loop_err    <= 1'b0;
    end else begin
      mem_rd_en <= 1'b0;
      if (state != W_IDLE && uframe_end) eof_pend <= 1'b1;

      case (state)
        W_IDLE: begin
          eof_pend <= 1'b0;
          if (uframe_start) begin
            scan_from <= '0;
            loop_err  <= 1'b0;
            state     <= W_PICK;
          end
        end

        W_PICK: begin
          if (eof || !pick_found) begin
            state <= W_IDLE;
          end else begin
            cur_list <= pick_idx;
            if (pick_head == '0) begin
              scan_from <= pick_idx + 1'b1;
            end else begin
              ptr         <= pick_head;
              mem_rd_en   <= 1'b1;
              mem_rd_addr <= pick_head;
              state       <= W_READ;
            end
          end
        end

        W_READ: state <= eof ? W_IDLE : W_EVAL;

        W_EVAL, W_REQ: begin
          if (state == W_EVAL && eof) begin
            state <= W_IDLE;
          end else if (state == W_EVAL && d_take) begin
            req_valid <= 1'b1;
            req_addr  <= ptr;
            req_list  <= cur_list;
            link_q    <= d_link;
            tail_q    <= d_tail;
            state     <= W_REQ;
          end else if (state == W_EVAL || req_ack) begin
            req_valid <= 1'b0;
            if (eof) begin
              state <= W_IDLE;
            end else if (adv_end || adv_err) begin
              if (adv_err) loop_err <= 1'b1;
              scan_from <= cur_list + 1'b1;
              state     <= W_PICK;
            end else begin
              ptr         <= adv_link;
              mem_rd_en   <= 1'b1;
              mem_rd_addr <= adv_link;
              state       <= W_READ;
            end
          end
        end

        default: state <= W_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ack |=> req_valid && $stable(req_addr) && $stable(req_list)); // R4
  AST_NULL_NEVER_READ: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> mem_rd_addr != '0); // R6
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en); // R3
  AST_EOF_STOPS: assert property (@(posedge clk) disable iff (rst)
    uframe_end && !req_valid |=> !mem_rd_en && !req_valid); // R8
  AST_ERR_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(loop_err) |-> $past(busy)); // R9
endmodule

// File: tb/tb_sched_walker.sv
module tb_sched_walker;
  localparam int AW = 8;
  localparam int DW = AW + 3;
  localparam int NL = 3;

  typedef struct packed {
    logic [2:0]  en;
    logic [7:0]  h0, h1, h2;
    logic [7:0]  cnt;
    logic        err;
  } vec_t;

  // chain A@1: 2 reqs; B@10: 1 req (tail flag); C@20: 2 reqs; D@40: loop, 16 reqs + err; E@30: 0
  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{3'b111, 8'd1,  8'd10, 8'd20, 8'd5,  1'b0},
    '{3'b101, 8'd1,  8'd10, 8'd20, 8'd4,  1'b0},
    '{3'b010, 8'd1,  8'd10, 8'd20, 8'd1,  1'b0},
    '{3'b111, 8'd0,  8'd20, 8'd10, 8'd3,  1'b0},
    '{3'b100, 8'd1,  8'd10, 8'd40, 8'd16, 1'b1},
    '{3'b111, 8'd30, 8'd40, 8'd1,  8'd18, 1'b1},
    '{3'b000, 8'd1,  8'd10, 8'd20, 8'd0,  1'b0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic uframe_start = 1'b0, uframe_end = 1'b0;
  logic [NL-1:0] list_en = '0;
  logic [NL*AW-1:0] list_head = '0;
  logic mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [DW-1:0] mem_rd_data = '0;
  logic req_valid;
  logic [AW-1:0] req_addr;
  logic [1:0] req_list;
  logic req_ack = 1'b0;
  logic busy, loop_err;

  int checks = 0, errors = 0;
  int cycles = 0;
  bit ack_auto = 1'b1;
  int ack_dly = 0;
  int log_n = 0;
  logic [AW-1:0] log_addr [64];
  logic [1:0]    log_list [64];
  int exp_n;
  logic [AW-1:0] exp_addr [64];
  logic [1:0]    exp_list [64];
  logic          exp_err;
  int rd_zero = 0, rd_double = 0;
  logic rd_prev = 1'b0;
  logic [DW-1:0] mem [256];

  always #10 clk = ~clk;

  sched_walker #(.ADDR_W(AW), .MAX_STEPS(32)) dut (
    .clk(clk), .rst(rst), .uframe_start(uframe_start), .uframe_end(uframe_end),
    .list_en(list_en), .list_head(list_head),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .req_valid(req_valid), .req_addr(req_addr), .req_list(req_list), .req_ack(req_ack),
    .busy(busy), .loop_err(loop_err)
  );

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

  always @(negedge clk) begin
    if (mem_rd_en && mem_rd_addr == '0) rd_zero++;
    if (mem_rd_en && rd_prev) rd_double++;
    rd_prev = mem_rd_en;
  end

  // automatic acknowledge responder with request log
  always begin
    @(negedge clk);
    if (ack_auto && req_valid && !req_ack) begin
      if (log_n < 64) begin
        log_addr[log_n] = req_addr;
        log_list[log_n] = req_list;
      end
      log_n++;
      repeat (ack_dly) @(negedge clk);
      req_ack = 1'b1;
      @(negedge clk);
      req_ack = 1'b0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [DW-1:0] mk(logic done, logic act, logic tail, logic [AW-1:0] nxt);
    return {done, act, tail, nxt};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference walk from the requirements
  task automatic ref_walk(logic [2:0] en, logic [NL*AW-1:0] heads);
    exp_n = 0;
    exp_err = 1'b0;
    for (int l = 0; l < NL; l++) begin
      if (en[l]) begin
        logic [AW-1:0] p;
        int steps;
        p = heads[l*AW +: AW];
        steps = 0;
        while (p != '0) begin
          logic [DW-1:0] d;
          d = mem[p];
          steps++;
          if (d[AW+1] && !d[AW+2]) begin
            exp_addr[exp_n] = p;
            exp_list[exp_n] = 2'(l);
            exp_n++;
          end
          if (d[AW] || d[AW-1:0] == '0) break;
          if (steps == 32) begin exp_err = 1'b1; break; end
          p = d[AW-1:0];
        end
      end
    end
  endtask

  task automatic start_frame();
    @(negedge clk); uframe_start = 1'b1;
    @(negedge clk); uframe_start = 1'b0;
  endtask

  task automatic wait_idle();
    int t;
    t = 0;
    while (busy && t < 5000) begin @(negedge clk); t++; end
    @(negedge clk);
  endtask

  task automatic run_case(string tag, logic [2:0] en, logic [7:0] h0, logic [7:0] h1,
                          logic [7:0] h2, int cnt, logic err, int poke);
    int ok;
    list_en = en;
    list_head = {h2, h1, h0};
    log_n = 0;
    ref_walk(en, {h2, h1, h0});
    start_frame();
    if (poke > 0) begin
      repeat (poke) @(negedge clk);
      uframe_start = 1'b1; @(negedge clk); uframe_start = 1'b0;
    end
    wait_idle();
    check({tag, " R4 request count"}, log_n, cnt);
    check({tag, " R9 loop_err"}, loop_err, err);
    check({tag, " R2 model count"}, exp_n, cnt);
    ok = (log_n == exp_n) ? 1 : 0;
    for (int i = 0; i < exp_n && i < log_n && i < 64; i++)
      if (log_addr[i] !== exp_addr[i] || log_list[i] !== exp_list[i]) ok = 0;
    check({tag, " R2 R5 R7 request order"}, ok, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[1]  = mk(0, 1, 0, 8'd2);
    mem[2]  = mk(1, 0, 0, 8'd3);
    mem[3]  = mk(0, 1, 0, 8'd0);
    mem[10] = mk(0, 1, 1, 8'd11);
    mem[11] = mk(0, 1, 0, 8'd0);
    mem[20] = mk(1, 1, 0, 8'd21);
    mem[21] = mk(0, 0, 0, 8'd22);
    mem[22] = mk(0, 1, 0, 8'd23);
    mem[23] = mk(0, 1, 0, 8'd0);
    mem[30] = mk(1, 0, 0, 8'd0);
    mem[40] = mk(0, 1, 0, 8'd41);
    mem[41] = mk(1, 0, 0, 8'd40);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 req_valid", req_valid, 0);
    check("R1 mem_rd_en", mem_rd_en, 0);
    check("R1 loop_err", loop_err, 0);

    for (int v = 0; v < NV; v++) begin
      ack_dly = v % 3;
      run_case($sformatf("vec%0d", v), VEC[v].en, VEC[v].h0, VEC[v].h1, VEC[v].h2,
               int'(VEC[v].cnt), VEC[v].err, 0);
    end

    // R10: start strobe while busy changes nothing
    run_case("R10 restart-ignored", 3'b100, 8'd0, 8'd0, 8'd40, 16, 1'b1, 12);

    // R8: end of microframe with a pending request
    ack_auto = 1'b0;
    list_en = 3'b100;
    list_head = {8'd40, 8'd0, 8'd0};
    start_frame();
    begin
      int t;
      t = 0;
      while (!req_valid && t < 100) begin @(negedge clk); t++; end
    end
    uframe_end = 1'b1; @(negedge clk); uframe_end = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 request held after end", req_valid, 1);
    check("R8 still busy", busy, 1);
    req_ack = 1'b1; @(negedge clk); req_ack = 1'b0;
    check("R8 idle after ack", busy, 0);
    check("R8 request dropped", req_valid, 0);
    repeat (5) @(negedge clk);
    check("R8 no new request", req_valid, 0);
    ack_auto = 1'b1;
    ack_dly = 0;
    run_case("R8 next frame", 3'b010, 8'd0, 8'd10, 8'd0, 1, 1'b0, 0);

    check("R6 address 0 read count", rd_zero, 0);
    check("R3 back-to-back read strobes", rd_double, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule